// File: doc/BRIEF.md
# Feedback Slew Guard with Short-Circuit Latch

This block watches a digital code for the feedback headroom of a resonant converter's output regulator, that is the supply voltage minus the feedback-pin voltage. A new code arrives once per switching cycle with a one-clock valid strobe. The headroom grows when current through the optical feedback path rises. When it rises by more than one fifth between two consecutive cycles, the block asks the synchronous-rectifier gate timer to cut every on-time by a fixed number of ticks. That request is held for a long fixed window, so that a load step cannot lead to shoot-through.

The same input also drives a short-circuit detector. A headroom code below a limit that persists for a debounce interval sets a fault flag. The fault flag stays set until reset or until a clear pulse. While it is set, no shrink is requested, and any running shrink window is cancelled.

The ratio, the window length, the shrink amount, the short limit and the debounce length are all parameters. At a 100 MHz clock the defaults correspond to a 1.4 µs shrink, a 90 µs window and a 16 µs debounce.

Top module: `fb_slew_guard`

## Requirements
- R1: After reset, `shrink_active` is 0, `shrink_ticks` is 0 and `short_fault` is 0.
- R2: A sample triggers a shrink when DEN × code > NUM × previous code (defaults NUM=6 and DEN=5, strict). A sample that is exactly 120 % of the previous one, or any smaller sample, does not trigger.
- R3: The first sample after reset only becomes the previous code and never triggers a shrink, whatever its value.
- R4: A trigger on the clock edge that takes the sample makes `shrink_active` 1 right after that edge. It stays 1 for exactly HOLD_TICKS clock cycles and then returns to 0.
- R5: A new trigger while a window is running restarts the window at the full HOLD_TICKS.
- R6: `shrink_ticks` equals SHRINK_TICKS while `shrink_active` is 1, and 0 otherwise.
- R7: A sample with code < SHORT_LIMIT arms the detector. If no sample with code ≥ SHORT_LIMIT arrives for DEB_TICKS clock cycles after the arming edge, `short_fault` becomes 1. An intervening sample at or above the limit restarts the count.
- R8: `short_fault` stays 1 whatever samples follow. It returns to 0 only on reset or on the edge that sees `fault_clear` high.
- R9: While `short_fault` is 1, `shrink_active` is 0 even if a trigger occurs, and any running window is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-clock strobe: a new headroom code is present |
| headroom_code | input | CODE_W | Unsigned headroom code for this switching cycle |
| fault_clear | input | 1 | Clears a latched short-circuit fault |
| shrink_active | output | 1 | Shrink request to the gate timer is in force |
| shrink_ticks | output | TICK_W | On-time reduction in clock ticks (0 when inactive) |
| short_fault | output | 1 | Latched short-circuit fault |

## Verification
The hardest situation to bring about is a trigger that arrives while the fault is latched. It must be absorbed, and no window may survive once the fault is cleared. The stimulus first holds a low code past the debounce to latch the fault. It then sends a sharply larger code that meets the ratio test, checks that no shrink appears, and pulses the clear. Windows that are restarted, and debounce counts that are interrupted one cycle short, are reached by timing sample strobes against the known window and debounce lengths.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   // Extra bits needed to scale a code by a ratio term (terms must stay below 16).
   localparam int RATIO_W = 4;
   localparam int RATIO_MAX = (1 << RATIO_W) - 1;

   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction
endpackage

// File: rtl/fbg_ratio_detect.sv
module fbg_ratio_detect #(
   parameter int CODE_W = 10,
   parameter int NUM    = 6,
   parameter int DEN    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              trig_o
);
   localparam int PW = CODE_W + fbg_pkg::RATIO_W;

   logic [CODE_W-1:0] prev_q;
   logic              have_prev_q;
   logic [PW-1:0]     cur_scaled;
   logic [PW-1:0]     prev_scaled;

   always_comb begin
      cur_scaled  = PW'(code_i) * PW'(DEN);
      prev_scaled = PW'(prev_q) * PW'(NUM);
   end

   assign trig_o = valid_i && have_prev_q && (cur_scaled > prev_scaled);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q      <= '0;
         have_prev_q <= 1'b0;
      end else if (valid_i) begin
         prev_q      <= code_i;
         have_prev_q <= 1'b1;
      end
   end

   // R3: the sample that first fills the history never triggers
   a_r3_first_sample_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(have_prev_q) |-> !$past(trig_o));

   // R2: history always follows the latest valid sample
   a_r2_history_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> prev_q == $past(code_i));
endmodule

// File: rtl/fbg_hold_timer.sv
module fbg_hold_timer #(
   parameter int HOLD_TICKS = 9000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic fault_i,
   output logic active_o
);
   localparam int CW = fbg_pkg::cnt_width(HOLD_TICKS);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (fault_i)          cnt_q <= '0;
      else if (trig_i)           cnt_q <= CW'(HOLD_TICKS);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   // R5: any accepted trigger loads the full window
   a_r5_window_reload: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i && !fault_i |=> cnt_q == CW'(HOLD_TICKS));

   // R4: a running window counts down by one per cycle
   a_r4_window_decay: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) && !trig_i && !fault_i |=> cnt_q == $past(cnt_q) - 1'b1);

   // R9: a fault discards the window
   a_r9_fault_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> !active_o);
endmodule

// File: rtl/fbg_short_debounce.sv
module fbg_short_debounce #(
   parameter int CODE_W      = 10,
   parameter int SHORT_LIMIT = 28,
   parameter int DEB_TICKS   = 1600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              clear_i,
   output logic              fault_o
);
   localparam int CW = fbg_pkg::cnt_width(DEB_TICKS);

   logic          low_q;
   logic [CW-1:0] cnt_q;
   logic          fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_q <= 1'b0;
      else if (valid_i) low_q <= (code_i < CODE_W'(SHORT_LIMIT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else if (fault_q || !low_q) begin
         cnt_q   <= '0;
      end else if (cnt_q == CW'(DEB_TICKS - 1)) begin
         fault_q <= 1'b1;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign fault_o = fault_q;

   // R7: the fault only rises after a full debounce of low headroom
   a_r7_debounced_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q) |-> $past(low_q) && $past(cnt_q) == CW'(DEB_TICKS - 1));

   // R8: latched until cleared
   a_r8_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q && !clear_i |=> fault_q);

   // R8: a clear always drops the fault
   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !fault_q);
endmodule

// File: rtl/fb_slew_guard.sv
module fb_slew_guard #(
   parameter int CODE_W       = 10,
   parameter int RATIO_NUM    = 6,
   parameter int RATIO_DEN    = 5,
   parameter int HOLD_TICKS   = 9000,
   parameter int SHRINK_TICKS = 140,
   parameter int TICK_W       = 8,
   parameter int SHORT_LIMIT  = 28,
   parameter int DEB_TICKS    = 1600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_valid,
   input  logic [CODE_W-1:0] headroom_code,
   input  logic              fault_clear,
   output logic              shrink_active,
   output logic [TICK_W-1:0] shrink_ticks,
   output logic              short_fault
);
   generate
      if (RATIO_NUM < 1 || RATIO_NUM > fbg_pkg::RATIO_MAX ||
          RATIO_DEN < 1 || RATIO_DEN > fbg_pkg::RATIO_MAX) begin : g_bad_ratio
         $error("ratio terms must lie in 1..15");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("HOLD_TICKS must be at least 1");
      end
      if (DEB_TICKS < 1) begin : g_bad_deb
         $error("DEB_TICKS must be at least 1");
      end
      if (SHRINK_TICKS >= (1 << TICK_W)) begin : g_bad_tick
         $error("SHRINK_TICKS does not fit in TICK_W");
      end
      if (SHORT_LIMIT > (1 << CODE_W)) begin : g_bad_limit
         $error("SHORT_LIMIT exceeds the code range");
      end
   endgenerate

   logic trig;
   logic window_on;
   logic fault;

   fbg_ratio_detect #(
      .CODE_W (CODE_W),
      .NUM    (RATIO_NUM),
      .DEN    (RATIO_DEN)
   ) u_ratio (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (sample_valid),
      .code_i  (headroom_code),
      .trig_o  (trig)
   );

   fbg_hold_timer #(
      .HOLD_TICKS (HOLD_TICKS)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_i   (trig),
      .fault_i  (fault),
      .active_o (window_on)
   );

   fbg_short_debounce #(
      .CODE_W      (CODE_W),
      .SHORT_LIMIT (SHORT_LIMIT),
      .DEB_TICKS   (DEB_TICKS)
   ) u_short (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (sample_valid),
      .code_i  (headroom_code),
      .clear_i (fault_clear),
      .fault_o (fault)
   );

   assign short_fault   = fault;
   assign shrink_active = window_on && !fault;
   assign shrink_ticks  = shrink_active ? TICK_W'(SHRINK_TICKS) : '0;

   // R9: a trigger during a fault leaves the request off
   a_r9_no_shrink_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
      short_fault && trig |=> !shrink_active);

   // R6: shrink amount and flag agree at the ports
   a_r6_ticks_match_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (shrink_ticks != '0) == shrink_active);
endmodule

// File: tb/fb_slew_guard_test.sv
module fb_slew_guard_test;
   localparam int CW   = 10;
   localparam int HOLD = 20;
   localparam int SHR  = 140;
   localparam int TW   = 8;
   localparam int LIM  = 10;
   localparam int DEB  = 10;
   localparam int NV   = 10;

   // ratio-walk vectors: code, expected trigger (R2, R3)
   localparam logic [CW-1:0] V_CODE [NV] = '{10'd100, 10'd119, 10'd143, 10'd171, 10'd206,
                                             10'd200, 10'd240, 10'd50,  10'd61,  10'd1023};
   localparam bit            V_TRIG [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
                                             1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_valid = 1'b0;
   logic [CW-1:0] headroom_code = '0;
   logic          fault_clear = 1'b0;
   logic          shrink_active;
   logic [TW-1:0] shrink_ticks;
   logic          short_fault;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fb_slew_guard #(
      .CODE_W(CW), .RATIO_NUM(6), .RATIO_DEN(5), .HOLD_TICKS(HOLD),
      .SHRINK_TICKS(SHR), .TICK_W(TW), .SHORT_LIMIT(LIM), .DEB_TICKS(DEB)
   ) uut (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .headroom_code(headroom_code), .fault_clear(fault_clear),
      .shrink_active(shrink_active), .shrink_ticks(shrink_ticks),
      .short_fault(short_fault)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(input int code);
      @(negedge clk);
      sample_valid  = 1'b1;
      headroom_code = CW'(code);
      @(negedge clk);
      sample_valid  = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
         end
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 active", int'(shrink_active), 0);
      check("R1 ticks", int'(shrink_ticks), 0);
      check("R1 fault", int'(short_fault), 0);

      // R2/R3 ratio walk: first entry is the first sample after reset
      for (int v = 0; v < NV; v++) begin
         send(int'(V_CODE[v]));
         check(v == 0 ? "R3 first sample" : "R2 ratio", int'(shrink_active), int'(V_TRIG[v]));
         check("R6 ticks", int'(shrink_ticks), V_TRIG[v] ? SHR : 0);
         idle(HOLD + 2);
         check("R4 window over", int'(shrink_active), 0);
      end

      // R4 exact window length
      send(100);
      send(200);
      check("R4 start", int'(shrink_active), 1);
      idle(HOLD - 1);
      check("R4 last cycle", int'(shrink_active), 1);
      idle(1);
      check("R4 end", int'(shrink_active), 0);

      // R5 retrigger restarts
      send(100);
      send(200);
      idle(8);
      send(100);
      send(200);
      idle(HOLD - 1);
      check("R5 extended", int'(shrink_active), 1);
      idle(1);
      check("R5 end", int'(shrink_active), 0);
      idle(2);

      // R7 debounce of low headroom
      send(5);
      idle(DEB - 1);
      check("R7 not yet", int'(short_fault), 0);
      idle(1);
      check("R7 set", int'(short_fault), 1);

      // R9 trigger during fault is absorbed; R8 fault latched
      send(100);
      check("R9 no shrink", int'(shrink_active), 0);
      check("R9 ticks zero", int'(shrink_ticks), 0);
      idle(5);
      check("R8 latched", int'(short_fault), 1);
      @(negedge clk);
      fault_clear = 1'b1;
      @(negedge clk);
      fault_clear = 1'b0;
      check("R8 clear", int'(short_fault), 0);
      check("R9 window dropped", int'(shrink_active), 0);

      // R7 interrupted debounce
      send(5);
      idle(DEB - 3);
      send(100);
      idle(DEB + 5);
      check("R7 interrupted", int'(short_fault), 0);
      idle(HOLD + 2);

      // R8 reset clears fault, then R3 after reset
      send(5);
      idle(DEB + 2);
      check("R8 set again", int'(short_fault), 1);
      do_reset();
      check("R8 reset clears", int'(short_fault), 0);
      send(900);
      check("R3 after reset", int'(shrink_active), 0);
      send(1000);
      check("R2 below ratio", int'(shrink_active), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule